// File: doc/BRIEF.md
# Event-Triggered Single-Move Transfer Controller

The controller services peripheral events by moving one data item without processor involvement. It holds eight channels. Each channel has a 16-bit control word, a source pointer and a destination pointer, and all three are loaded and read back through a simple register port. When an event arrives with a channel index, the controller checks that channel's count.

If the count is nonzero, the controller reads one byte or one word from the source pointer and writes it to the destination pointer. Addresses lie in a flat 64 KB space. It then advances at most one pointer and updates the count. If the count is zero, it moves nothing and raises a one-cycle request so that the regular interrupt handler runs instead.

Triggers arrive one at a time. Choosing among competing events happens upstream of this block. The memory side is a synchronous bus, and read data appears the cycle after the read strobe.

Top module: `evtxfer_ctrl`

## Requirements
- R1: After reset, every control word and pointer of every channel reads 0000h, and `busy`, `done`, `intReq`, `memRd` and `memWr` are low.
- R2: `cfgSel` picks the register: 0 is the control word, 1 is the source pointer, 2 is the destination pointer. A control word is laid out as follows:
  - count in bits 7:0
  - width flag in bit 8 (0 = word, 1 = byte)
  - step mode in bits 10:9
  - bits 15:11 always read zero
- R3: Writing step mode 11 stores mode 10.
- R4: A trigger on a channel with a nonzero count produces exactly one bus read at the source pointer and then exactly one bus write at the destination pointer, carrying the data read.
  - For a word, `memByte` is 0 and all 16 bits are used.
  - For a byte, `memByte` is 1 and the data is in bits 7:0 with bits 15:8 zero.
- R5: After a transfer, the pointers move by step mode:
  - mode 00 leaves both pointers unchanged
  - mode 01 advances the destination pointer
  - mode 10 advances the source pointer
  - the step is 2 for a word and 1 for a byte
  - the pointer wraps modulo 2^16
- R6: After a transfer, the count drops by one, except that a count of FFh stays FFh.
- R7: A trigger on a channel whose count is 00h causes no bus access, changes no register, keeps `busy` low and pulses `intReq` for one cycle, in the cycle after the trigger.
- R8: On word transfers, address bit 0 is driven as 0 on both the read and the write. The stored pointer keeps its own bit 0.
- R9: `busy` is high for exactly the three cycles after an accepted trigger. `done` is high for one cycle, the cycle after the write, and `busy` is low in that cycle.
- R10: A trigger that arrives while `busy` is high is ignored.
- R11: A transfer on one channel leaves every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register port write strobe |
| cfgCh | input | 3 | Register port channel index |
| cfgSel | input | 2 | Register select: 0 control, 1 source, 2 destination |
| cfgWdata | input | 16 | Register port write data |
| cfgRdata | output | 16 | Register port read data (combinational) |
| trigValid | input | 1 | Event trigger, one cycle |
| trigCh | input | 3 | Channel index of the trigger |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer completion pulse |
| intReq | output | 1 | One-cycle request for the regular interrupt routine |
| memAddr | output | 16 | Bus byte address |
| memRd | output | 1 | Bus read strobe |
| memWr | output | 1 | Bus write strobe |
| memByte | output | 1 | 1 for a byte access, 0 for a word access |
| memWdata | output | 16 | Bus write data |
| memRdata | input | 16 | Bus read data, valid the cycle after `memRd` |

## Verification
The bench builds the controller with its default parameters: eight channels, 16-bit pointers and an 8-bit count. With these values the FFh hold code, the FFFEh-to-0000h pointer wrap and the count running down from 1 to 0 all take only a few triggers to reach.

It drives every step mode, including the remapped reserved code, in both byte and word width. It also covers an odd source pointer on a word move and a trigger that arrives in the middle of a transfer. After each move it reads back the channel that moved and a neighbouring channel.

// File: rtl/evtxfer_pkg.sv
package evtxfer_pkg;

  typedef struct packed {
    logic loadCh;
    logic rdPhase;
    logic capture;
    logic wrPhase;
  } xferStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_WRITE = 2'd3
  } xferState_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_DST  = 2'd2;

  localparam logic [1:0] STEP_NONE = 2'b00;
  localparam logic [1:0] STEP_DST  = 2'b01;
  localparam logic [1:0] STEP_SRC  = 2'b10;
  localparam logic [1:0] STEP_RSV  = 2'b11;

endpackage

// File: rtl/evtxfer_control.sv
module evtxfer_control
  import evtxfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigValid,
  input  logic        trigCntZero,
  output xferStrobe_t strb,
  output logic        busy,
  output logic        done,
  output logic        intReq
);

  xferState_t stateQ, stateD;
  logic doneQ, intQ;
  logic accept;

  assign accept = (stateQ == ST_IDLE) && trigValid && !trigCntZero;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (accept) stateD = ST_READ;
      ST_READ:  stateD = ST_HOLD;
      ST_HOLD:  stateD = ST_WRITE;
      ST_WRITE: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      intQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (stateQ == ST_WRITE);
      intQ   <= (stateQ == ST_IDLE) && trigValid && trigCntZero;
    end
  end

  always_comb begin
    strb.loadCh  = accept;
    strb.rdPhase = (stateQ == ST_READ);
    strb.capture = (stateQ == ST_HOLD);
    strb.wrPhase = (stateQ == ST_WRITE);
  end

  assign busy   = (stateQ != ST_IDLE);
  assign done   = doneQ;
  assign intReq = intQ;

  // R7: the fallback request never overlaps a move
  assert_int_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (!busy && !strb.rdPhase && !strb.wrPhase));

  // R9: the write phase is followed by done with busy released
  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPhase |=> (done && !busy));

  // R4: read, capture and write phases are exclusive
  assert_phase_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdPhase, strb.capture, strb.wrPhase}));

  // R10: once started, busy stays up until the write phase
  assert_busy_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.wrPhase) |=> busy);

  // R4: one read per transfer, followed by capture
  assert_single_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdPhase |=> (strb.capture && !strb.rdPhase));

endmodule

// File: rtl/evtxfer_datapath.sv
module evtxfer_datapath
  import evtxfer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int REG_W  = 16,
  parameter int CH_W   = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strb,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [1:0]        cfgSel,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic [CH_W-1:0]   trigCh,
  output logic              trigCntZero,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memByte,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata
);

  localparam int WIDTH_BIT = CNT_W;
  localparam int MODE_LO   = CNT_W + 1;
  localparam int MODE_HI   = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_HOLD = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cntQ  [NUM_CH];
  logic              byteQ [NUM_CH];
  logic [1:0]        modeQ [NUM_CH];
  logic [ADDR_W-1:0] srcQ  [NUM_CH];
  logic [ADDR_W-1:0] dstQ  [NUM_CH];

  logic [CH_W-1:0] activeChQ;
  logic [15:0]     dataQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic cfgHit, commitHit;
    logic [1:0] modeIn;
    logic [ADDR_W-1:0] step;

    assign cfgHit    = cfgWe && (cfgCh == CH_W'(i));
    assign commitHit = strb.wrPhase && (activeChQ == CH_W'(i));
    assign modeIn    = (cfgWdata[MODE_HI:MODE_LO] == STEP_RSV) ? STEP_SRC
                                                                : cfgWdata[MODE_HI:MODE_LO];
    assign step      = byteQ[i] ? ADDR_W'(1) : ADDR_W'(2);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[i]  <= '0;
        byteQ[i] <= 1'b0;
        modeQ[i] <= STEP_NONE;
      end else if (cfgHit && cfgSel == SEL_CTRL) begin
        cntQ[i]  <= cfgWdata[CNT_W-1:0];
        byteQ[i] <= cfgWdata[WIDTH_BIT];
        modeQ[i] <= modeIn;
      end else if (commitHit && cntQ[i] != CNT_HOLD) begin
        cntQ[i]  <= cntQ[i] - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcQ[i] <= '0;
      end else if (cfgHit && cfgSel == SEL_SRC) begin
        srcQ[i] <= cfgWdata[ADDR_W-1:0];
      end else if (commitHit && modeQ[i] == STEP_SRC) begin
        srcQ[i] <= srcQ[i] + step;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dstQ[i] <= '0;
      end else if (cfgHit && cfgSel == SEL_DST) begin
        dstQ[i] <= cfgWdata[ADDR_W-1:0];
      end else if (commitHit && modeQ[i] == STEP_DST) begin
        dstQ[i] <= dstQ[i] + step;
      end
    end

    // R3: the reserved step code never reaches the stored mode
    assert_mode_remap_R3: assert property (@(posedge clk) disable iff (!rstN)
      modeQ[i] != STEP_RSV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeChQ <= '0;
      dataQ     <= '0;
    end else begin
      if (strb.loadCh)  activeChQ <= trigCh;
      if (strb.capture) dataQ     <= memRdata;
    end
  end

  logic              actByte;
  logic [CNT_W-1:0]  actCnt;
  logic [1:0]        actMode;
  logic [ADDR_W-1:0] rawAddr;

  assign actByte     = byteQ[activeChQ];
  assign actCnt      = cntQ[activeChQ];
  assign actMode     = modeQ[activeChQ];
  assign trigCntZero = (cntQ[trigCh] == '0);
  assign rawAddr     = strb.wrPhase ? dstQ[activeChQ] : srcQ[activeChQ];
  assign memAddr     = {rawAddr[ADDR_W-1:1], rawAddr[0] & actByte};
  assign memByte     = actByte;
  assign memWdata    = actByte ? {8'h00, dataQ[7:0]} : dataQ;

  always_comb begin
    cfgRdata = '0;
    unique case (cfgSel)
      SEL_CTRL: begin
        cfgRdata[CNT_W-1:0]       = cntQ[cfgCh];
        cfgRdata[WIDTH_BIT]       = byteQ[cfgCh];
        cfgRdata[MODE_HI:MODE_LO] = modeQ[cfgCh];
      end
      SEL_SRC: cfgRdata[ADDR_W-1:0] = srcQ[cfgCh];
      SEL_DST: cfgRdata[ADDR_W-1:0] = dstQ[cfgCh];
      default: cfgRdata = '0;
    endcase
  end

  logic ctrlClash;
  assign ctrlClash = cfgWe && (cfgCh == activeChQ);

  // R8: word accesses never drive an odd address
  assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.rdPhase || strb.wrPhase) && !actByte) |-> (memAddr[0] == 1'b0));

  // R6: count decrements once per move, holding at the all-ones code
  assert_count_rule_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPhase && !ctrlClash) |=>
      (cntQ[$past(activeChQ)] == (($past(actCnt) == CNT_HOLD) ? CNT_HOLD
                                                              : $past(actCnt) - 1'b1)));

  // R5: mode 00 leaves both pointers of the moving channel alone
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPhase && !ctrlClash && actMode == STEP_NONE) |=>
      ($stable(srcQ[$past(activeChQ)]) && $stable(dstQ[$past(activeChQ)])));

endmodule

// File: rtl/evtxfer_ctrl.sv
module evtxfer_ctrl
  import evtxfer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int REG_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [1:0]        cfgSel,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  cfgRdata,
  input  logic              trigValid,
  input  logic [CH_W-1:0]   trigCh,
  output logic              busy,
  output logic              done,
  output logic              intReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic              memByte,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata
);

  xferStrobe_t strb;
  logic trigCntZero;

  evtxfer_control u_ctl (
    .clk(clk), .rstN(rstN),
    .trigValid(trigValid), .trigCntZero(trigCntZero),
    .strb(strb), .busy(busy), .done(done), .intReq(intReq)
  );

  evtxfer_datapath #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W), .CH_W(CH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .trigCh(trigCh), .trigCntZero(trigCntZero),
    .memAddr(memAddr), .memByte(memByte),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  assign memRd = strb.rdPhase;
  assign memWr = strb.wrPhase;

  // R4: the bus never reads and writes together
  assert_no_rdwr_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

endmodule

// File: tb/evtxfer_ctrl_test.sv
module evtxfer_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgCh = '0;
  logic [1:0]  cfgSel = '0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic        trigValid = 1'b0;
  logic [2:0]  trigCh = '0;
  logic        busy, done, intReq;
  logic [15:0] memAddr;
  logic        memRd, memWr, memByte;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;

  evtxfer_ctrl uut (.*);

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (memRd)
      memRdata <= memByte ? {8'h00, mem[memAddr[7:0]]}
                          : {mem[memAddr[7:0] + 8'd1], mem[memAddr[7:0]]};
    if (memWr) begin
      mem[memAddr[7:0]] <= memWdata[7:0];
      if (!memByte) mem[memAddr[7:0] + 8'd1] <= memWdata[15:8];
    end
  end

  int rdCount = 0, wrCount = 0;
  logic [15:0] rdAddr, wrAddr, wrData;
  logic wrByte;
  always @(negedge clk) begin
    if (memRd) begin rdCount++; rdAddr = memAddr; end
    if (memWr) begin wrCount++; wrAddr = memAddr; wrData = memWdata; wrByte = memByte; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input int ch, input int sel, input int val);
    @(negedge clk);
    cfgWe = 1'b1; cfgCh = 3'(ch); cfgSel = 2'(sel); cfgWdata = 16'(val);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic regRd(input int ch, input int sel, output int val);
    cfgCh = 3'(ch); cfgSel = 2'(sel);
    #1;
    val = int'(cfgRdata);
  endtask

  task automatic expectReg(input int ch, input int sel, input int exp, input string tag);
    int v;
    regRd(ch, sel, v);
    check(v == exp, tag, v, exp);
  endtask

  int busyCyc, intPulses, rd0, wr0;
  bit sawDone, doneBusy;

  task automatic fire(input int ch, input int injectCh);
    @(negedge clk);
    trigValid = 1'b1; trigCh = 3'(ch);
    rd0 = rdCount; wr0 = wrCount;
    @(negedge clk);
    trigValid = 1'b0;
    busyCyc = 0; intPulses = 0; sawDone = 0; doneBusy = 0;
    for (int k = 0; k < 10; k++) begin
      if (busy) busyCyc++;
      if (done) begin sawDone = 1; doneBusy = busy; end
      if (intReq) intPulses++;
      @(negedge clk);
      if (injectCh >= 0 && k == 0) begin trigValid = 1'b1; trigCh = 3'(injectCh); end
      else trigValid = 1'b0;
    end
  endtask

  task automatic test_reset;
    check(!busy && !done && !intReq && !memRd && !memWr, "R1 outputs idle", busy, 0);
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 3; s++)
        expectReg(c, s, 0, "R1 register reset");
  endtask

  task automatic test_regs;
    regWr(2, 0, 16'h0212); expectReg(2, 0, 16'h0212, "R2 control readback");
    regWr(2, 1, 16'hBEEF); expectReg(2, 1, 16'hBEEF, "R2 source readback");
    regWr(2, 2, 16'h1357); expectReg(2, 2, 16'h1357, "R2 destination readback");
    regWr(2, 0, 16'hFFFF); expectReg(2, 0, 16'h05FF, "R3 reserved mode remap, R2 upper zero");
    regWr(2, 1, 0); regWr(2, 2, 0);
  endtask

  task automatic test_word_src;
    mem[8'h10] = 8'h34; mem[8'h11] = 8'h12;
    regWr(1, 1, 16'h0010); regWr(1, 2, 16'h0040); regWr(1, 0, 16'h0403);
    fire(1, -1);
    check(rdCount - rd0 == 1 && wrCount - wr0 == 1, "R4 one read one write", wrCount - wr0, 1);
    check(rdAddr == 16'h0010, "R4 read address", rdAddr, 16'h0010);
    check(wrAddr == 16'h0040, "R4 write address", wrAddr, 16'h0040);
    check(wrData == 16'h1234 && !wrByte, "R4 word data", wrData, 16'h1234);
    check(busyCyc == 3, "R9 busy length", busyCyc, 3);
    check(sawDone && !doneBusy, "R9 done pulse with busy low", sawDone, 1);
    expectReg(1, 1, 16'h0012, "R5 source +2 word");
    expectReg(1, 2, 16'h0040, "R5 destination held in mode 10");
    expectReg(1, 0, 16'h0402, "R6 count decrement");
    expectReg(0, 0, 0, "R11 other channel control");
    expectReg(0, 1, 0, "R11 other channel source");
  endtask

  task automatic test_byte_dst;
    mem[8'h21] = 8'hA5;
    regWr(3, 1, 16'h0021); regWr(3, 2, 16'h0051); regWr(3, 0, 16'h0305);
    fire(3, -1);
    check(rdAddr == 16'h0021, "R4 byte read address", rdAddr, 16'h0021);
    check(wrAddr == 16'h0051 && wrByte, "R4 byte write address", wrAddr, 16'h0051);
    check(wrData == 16'h00A5, "R4 byte data", wrData, 16'h00A5);
    check(mem[8'h51] == 8'hA5, "R4 byte stored", mem[8'h51], 8'hA5);
    expectReg(3, 2, 16'h0052, "R5 destination +1 byte");
    expectReg(3, 1, 16'h0021, "R5 source held in mode 01");
    expectReg(3, 0, 16'h0304, "R6 byte count decrement");
  endtask

  task automatic test_hold_count;
    regWr(4, 1, 16'h0030); regWr(4, 2, 16'h0060); regWr(4, 0, 16'h00FF);
    fire(4, -1);
    fire(4, -1);
    check(sawDone, "R6 continuous transfer done", sawDone, 1);
    expectReg(4, 0, 16'h00FF, "R6 count FFh held");
    expectReg(4, 1, 16'h0030, "R5 mode 00 source held");
    expectReg(4, 2, 16'h0060, "R5 mode 00 destination held");
  endtask

  task automatic test_zero_count;
    regWr(5, 1, 16'h0088); regWr(5, 0, 16'h0400);
    fire(5, -1);
    check(intPulses == 1, "R7 interrupt pulse", intPulses, 1);
    check(busyCyc == 0 && !sawDone, "R7 no busy", busyCyc, 0);
    check(rdCount == rd0 && wrCount == wr0, "R7 no bus access", rdCount - rd0, 0);
    expectReg(5, 0, 16'h0400, "R7 control unchanged");
    expectReg(5, 1, 16'h0088, "R7 source unchanged");
    regWr(6, 1, 16'h0002); regWr(6, 2, 16'h0090); regWr(6, 0, 16'h0401);
    fire(6, -1);
    check(sawDone && intPulses == 0, "R6 last count moves", intPulses, 0);
    expectReg(6, 0, 16'h0400, "R6 count reaches zero");
    fire(6, -1);
    check(intPulses == 1 && wrCount == wr0, "R7 exhausted channel requests interrupt", intPulses, 1);
  endtask

  task automatic test_odd_word;
    mem[8'h12] = 8'h77; mem[8'h13] = 8'h66;
    regWr(7, 1, 16'h0013); regWr(7, 2, 16'h0071); regWr(7, 0, 16'h0402);
    fire(7, -1);
    check(rdAddr == 16'h0012, "R8 read bit0 cleared", rdAddr, 16'h0012);
    check(wrAddr == 16'h0070, "R8 write bit0 cleared", wrAddr, 16'h0070);
    check(wrData == 16'h6677, "R8 aligned word data", wrData, 16'h6677);
    expectReg(7, 1, 16'h0015, "R8 pointer keeps bit0");
  endtask

  task automatic test_wrap;
    regWr(0, 1, 16'h0000); regWr(0, 2, 16'hFFFE); regWr(0, 0, 16'h0201);
    fire(0, -1);
    expectReg(0, 2, 16'h0000, "R5 destination wraps");
    expectReg(0, 0, 16'h0200, "R6 wrap count");
  endtask

  task automatic test_busy_trigger;
    regWr(2, 1, 0); regWr(2, 0, 16'h05FF);
    fire(1, 2);
    check(rdCount - rd0 == 1 && wrCount - wr0 == 1, "R10 single transfer", rdCount - rd0, 1);
    expectReg(2, 1, 16'h0000, "R10 ignored trigger source");
    expectReg(1, 1, 16'h0014, "R10 active channel advanced");
    expectReg(1, 0, 16'h0401, "R10 active count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_regs();
    test_word_src();
    test_byte_dst();
    test_hold_count();
    test_zero_count();
    test_odd_word();
    test_wrap();
    test_busy_trigger();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule